// File: doc/BRIEF.md
# Translation Cache with Software Invalidation

This block is a small, fully associative store of finished virtual-to-physical translations that sits in front of a page-table walker. A lookup address is compared against every stored entry in the same cycle. On a match the block returns the physical address and the present/writable flags combinationally. With no match it raises a miss so that the walker can be started. When the walker finishes, its result is written back through the fill port.

Entries of three page sizes share one array. Each entry carries a size code, and its tag compare ignores the virtual bits that fall inside the page. The block does not watch memory for changes to the translation tables. Software keeps it consistent with two commands. A write to the root table register empties the whole array. A single-address invalidate removes the one entry that translates a given virtual address.

Top module: `tlb_xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: `lk_hit` and `lk_miss` are combinational from the lookup inputs and are both 0 while `lk_valid` is 0. With `lk_valid` at 1, `lk_miss` is the inverse of `lk_hit`.
- R3: A fill with size code 0 (4KB) makes later lookups in that page hit, with `lk_paddr` = {frame, vaddr[11:0]}. The neighbouring page still misses.
- R4: Size code 1 is a 2MB page and code 2 is a 1GB page; code 3 is treated as 4KB. A large entry matches every address whose bits above 21 (2MB) or above 30 (1GB) agree with it. The physical address then takes its low 21 or 30 bits from the virtual address, and the frame bits below that boundary are ignored.
- R5: `lk_present` and `lk_writable` return the flags given with the fill.
- R6: An invalidate removes the entry that translates `inv_vaddr` and leaves every other entry in place.
- R7: A pulse on `flush_root` leaves every entry invalid from the next cycle.
- R8: A fill with no overlapping entry takes the lowest-index free entry. If every entry is valid, a round-robin pointer picks the victim. The pointer starts at 0 and advances, wrapping around, only when an eviction takes place.
- R9: A fill whose page overlaps a valid entry is written into that entry, so no other entry is evicted.
- R10: When an invalidate and a fill arrive in the same cycle, the invalidate is applied first, and the fill may reuse the entry that the invalidate freed.
- R11: A fill in the same cycle as `flush_root` is discarded.
- R12: At most one entry matches any lookup. A fill clears every other entry whose page overlaps the new one, whatever its size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup matched no entry |
| lk_paddr | output | PA_W | Translated physical address |
| lk_present | output | 1 | Present flag of the matching entry |
| lk_writable | output | 1 | Writable flag of the matching entry |
| fill_valid | input | 1 | Store a walker result |
| fill_vaddr | input | VA_W | Virtual address that was walked |
| fill_size | input | 2 | Page size code: 0=4KB, 1=2MB, 2=1GB |
| fill_pfn | input | PA_W-12 | Physical frame number, in 4KB units |
| fill_present | input | 1 | Present flag to store |
| fill_writable | input | 1 | Writable flag to store |
| flush_root | input | 1 | Root register written: clear all entries |
| inv_valid | input | 1 | Single-address invalidate |
| inv_vaddr | input | VA_W | Address to invalidate |

## Verification
The bench builds the block with 4 entries, a 48-bit virtual address and a 40-bit physical address. With only four entries, a handful of 4KB fills is enough to fill the array. This brings eviction and pointer wrap within reach, along with refill in place and reuse of a slot freed by an invalidate in the same cycle. The 40-bit physical width is wide enough to hold a 1GB frame above 2GB, so the offset merge is exercised for both large page sizes. It is also checked against a 4KB entry that a 2MB fill absorbs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  localparam int unsigned PG_OFS_BITS = 12;
  localparam int unsigned LVL_BITS    = 9;

  // Number of low page-number bits that fall inside a page of the given size.
  function automatic int unsigned pg_shift(pg_size_e s);
    case (s)
      PG_2M:   return LVL_BITS;
      PG_1G:   return 2 * LVL_BITS;
      default: return 0;
    endcase
  endfunction

  // The larger of two page sizes; used to test whether two pages overlap.
  function automatic pg_size_e pg_coarser(pg_size_e a, pg_size_e b);
    return (pg_shift(a) >= pg_shift(b)) ? a : b;
  endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
  import tlb_pkg::*;
#(
  parameter int VPN_W = 36
) (
  input  logic             e_valid,
  input  logic [1:0]       e_size,
  input  logic [VPN_W-1:0] e_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [1:0]       fill_size,
  output logic             lk_match,
  output logic             inv_match,
  output logic             fill_overlap
);

  logic [VPN_W-1:0] own_mask;
  logic [VPN_W-1:0] ovl_mask;

  always_comb begin
    own_mask = {VPN_W{1'b1}} << pg_shift(pg_size_e'(e_size));
    ovl_mask = {VPN_W{1'b1}} <<
               pg_shift(pg_coarser(pg_size_e'(e_size), pg_size_e'(fill_size)));
  end

  assign lk_match     = e_valid && (((e_vpn ^ lk_vpn)   & own_mask) == '0);
  assign inv_match    = e_valid && (((e_vpn ^ inv_vpn)  & own_mask) == '0);
  assign fill_overlap = e_valid && (((e_vpn ^ fill_vpn) & ovl_mask) == '0);

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_go,
  input  logic [ENTRIES-1:0] free_vec,
  input  logic [ENTRIES-1:0] overlap_vec,
  output logic [IDX_W-1:0]   slot,
  output logic               evict
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] ovl_idx;

  always_comb begin
    free_idx = '0;
    ovl_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i])    free_idx = IDX_W'(i);
      if (overlap_vec[i]) ovl_idx  = IDX_W'(i);
    end
  end

  always_comb begin
    evict = 1'b0;
    if (|overlap_vec)   slot = ovl_idx;
    else if (|free_vec) slot = free_idx;
    else begin
      slot  = rr_q;
      evict = fill_go;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (evict) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

endmodule

// File: rtl/tlb_xlat_cache.sv
module tlb_xlat_cache
  import tlb_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - PG_OFS_BITS,
  localparam int PFN_W  = PA_W - PG_OFS_BITS,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_present,
  output logic             lk_writable,
  input  logic             fill_valid,
  input  logic [VA_W-1:0]  fill_vaddr,
  input  logic [1:0]       fill_size,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_present,
  input  logic             fill_writable,
  input  logic             flush_root,
  input  logic             inv_valid,
  input  logic [VA_W-1:0]  inv_vaddr
);

  // Merge a frame with the in-page offset of a virtual address.
  function automatic logic [PA_W-1:0] xlat_merge(logic [PFN_W-1:0] pfn,
                                                 logic [VA_W-1:0]  va,
                                                 logic [1:0]       sz);
    logic [PA_W-1:0] low_mask;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ofs;
    low_mask = ({{(PA_W-1){1'b0}}, 1'b1} <<
                (PG_OFS_BITS + pg_shift(pg_size_e'(sz)))) - 1'b1;
    base     = {pfn, {PG_OFS_BITS{1'b0}}};
    ofs      = PA_W'(va[29:0]);
    return (base & ~low_mask) | (ofs & low_mask);
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [1:0]         size_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [PFN_W-1:0]   pfn_q   [ENTRIES];
  logic [ENTRIES-1:0] pres_q;
  logic [ENTRIES-1:0] wr_q;

  // Named internal events, also observed by the bound checker.
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] inv_match_vec;
  logic [ENTRIES-1:0] fill_ovl_raw;
  logic [ENTRIES-1:0] kept_vec;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] overlap_vec;
  logic               fill_go;
  logic               evict;
  logic [IDX_W-1:0]   fill_slot;

  logic [VPN_W-1:0] lk_vpn;
  logic [VPN_W-1:0] inv_vpn;
  logic [VPN_W-1:0] fill_vpn;

  assign lk_vpn   = lk_vaddr[VA_W-1:PG_OFS_BITS];
  assign inv_vpn  = inv_vaddr[VA_W-1:PG_OFS_BITS];
  assign fill_vpn = fill_vaddr[VA_W-1:PG_OFS_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_tag_cmp #(.VPN_W(VPN_W)) cmp_i (
      .e_valid      (valid_q[g]),
      .e_size       (size_q[g]),
      .e_vpn        (vpn_q[g]),
      .lk_vpn       (lk_vpn),
      .inv_vpn      (inv_vpn),
      .fill_vpn     (fill_vpn),
      .fill_size    (fill_size),
      .lk_match     (hit_vec[g]),
      .inv_match    (inv_match_vec[g]),
      .fill_overlap (fill_ovl_raw[g])
    );
  end

  // Invalidate acts before the fill: its victims count as free slots.
  assign kept_vec    = inv_valid ? (valid_q & ~inv_match_vec) : valid_q;
  assign free_vec    = ~kept_vec;
  assign overlap_vec = fill_ovl_raw & kept_vec;
  assign fill_go     = fill_valid && !flush_root;

  tlb_repl #(.ENTRIES(ENTRIES)) repl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_go     (fill_go),
    .free_vec    (free_vec),
    .overlap_vec (overlap_vec),
    .slot        (fill_slot),
    .evict       (evict)
  );

  // Lookup read-out: the hit vector is one-hot, so an AND-OR mux is enough.
  logic [PA_W-1:0] rd_pa;
  logic            rd_p;
  logic            rd_w;

  always_comb begin
    rd_pa = '0;
    rd_p  = 1'b0;
    rd_w  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        rd_pa = rd_pa | xlat_merge(pfn_q[i], lk_vaddr, size_q[i]);
        rd_p  = rd_p | pres_q[i];
        rd_w  = rd_w | wr_q[i];
      end
    end
  end

  assign lk_hit      = lk_valid && (|hit_vec);
  assign lk_miss     = lk_valid && !(|hit_vec);
  assign lk_paddr    = rd_pa;
  assign lk_present  = rd_p;
  assign lk_writable = rd_w;

  // Entry state update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_root) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!kept_vec[i] || (fill_go && overlap_vec[i])) valid_q[i] <= 1'b0;
      end
      if (fill_go) valid_q[fill_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      size_q[fill_slot] <= fill_size;
      vpn_q[fill_slot]  <= fill_vpn;
      pfn_q[fill_slot]  <= fill_pfn;
      pres_q[fill_slot] <= fill_present;
      wr_q[fill_slot]   <= fill_writable;
    end
  end

endmodule

// File: rtl/tlb_xlat_cache_chk.sv
module tlb_xlat_cache_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_root,
  input logic               fill_valid,
  input logic               inv_valid,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] inv_match_vec
);

  p_reset_empty_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (valid_q == '0));

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_root) |=> (valid_q != '0));

  p_inv_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid && !flush_root)
      |=> ((valid_q & $past(inv_match_vec)) == '0));

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_root |=> (valid_q == '0));

  p_fill_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_root && fill_valid) |=> ($countones(valid_q) == 0));

  p_single_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

bind tlb_xlat_cache tlb_xlat_cache_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_root    (flush_root),
  .fill_valid    (fill_valid),
  .inv_valid     (inv_valid),
  .lk_hit        (lk_hit),
  .lk_miss       (lk_miss),
  .valid_q       (valid_q),
  .hit_vec       (hit_vec),
  .inv_match_vec (inv_match_vec)
);

// File: tb/tlb_xlat_cache_tb_top.sv
module tlb_xlat_cache_tb_top;

  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam int N    = 4;
  localparam int PFN_W = PA_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             lk_valid = 0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             lk_hit, lk_miss, lk_present, lk_writable;
  logic [PA_W-1:0]  lk_paddr;
  logic             fill_valid = 0;
  logic [VA_W-1:0]  fill_vaddr = '0;
  logic [1:0]       fill_size = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic             fill_present = 0;
  logic             fill_writable = 0;
  logic             flush_root = 0;
  logic             inv_valid = 0;
  logic [VA_W-1:0]  inv_vaddr = '0;

  int n_vec = 0;
  int n_bad = 0;

  tlb_xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(N)) dut_i (
    .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_hit, .lk_miss, .lk_paddr,
    .lk_present, .lk_writable, .fill_valid, .fill_vaddr, .fill_size,
    .fill_pfn, .fill_present, .fill_writable, .flush_root, .inv_valid,
    .inv_vaddr
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Combinational lookup, sampled away from the clock edge.
  task automatic look(string req, logic [VA_W-1:0] va, bit exp_hit,
                      logic [PA_W-1:0] exp_pa = '0, bit exp_p = 0, bit exp_w = 0);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    #1;
    check(req, "hit", lk_hit, exp_hit);
    check(req, "miss", lk_miss, !exp_hit);
    if (exp_hit) begin
      check(req, "paddr", lk_paddr, exp_pa);
      check(req, "present", lk_present, exp_p);
      check(req, "writable", lk_writable, exp_w);
    end
    lk_valid = 1'b0;
  endtask

  task automatic set_fill(logic [VA_W-1:0] va, logic [1:0] sz, logic [PFN_W-1:0] pfn,
                          bit p, bit w);
    fill_valid = 1'b1; fill_vaddr = va; fill_size = sz;
    fill_pfn = pfn; fill_present = p; fill_writable = w;
  endtask

  task automatic fill(logic [VA_W-1:0] va, logic [1:0] sz, logic [PFN_W-1:0] pfn,
                      bit p = 1, bit w = 1);
    @(negedge clk);
    set_fill(va, sz, pfn, p, w);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inval(logic [VA_W-1:0] va);
    @(negedge clk);
    inv_valid = 1'b1; inv_vaddr = va;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_root = 1'b1;
    @(negedge clk);
    flush_root = 1'b0;
  endtask

  task automatic t_reset();
    look("R1", 48'h0000_abcd_e000, 0);
    look("R1", 48'h0, 0);
  endtask

  task automatic t_small_page();
    fill(48'h0000_abcd_e000, 2'd0, 28'hfedcb);
    look("R3", 48'h0000_abcd_e123, 1, 40'hfe_dcb1_23, 1, 1);
    look("R3", 48'h0000_abcd_f000, 0);
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = 48'h0000_abcd_e123;
    #1;
    check("R2", "hit with lk_valid low", lk_hit, 0);
    check("R2", "miss with lk_valid low", lk_miss, 0);
  endtask

  task automatic t_large_pages();
    fill(48'h0000_7fe0_0000, 2'd1, 28'h12400, 1, 1);
    look("R4", 48'h0000_7ff1_2345, 1, 40'h00_1251_2345, 1, 1);
    look("R4", 48'h0000_8000_0000, 0);
    fill(48'h0001_4000_0000, 2'd2, 28'h80000, 1, 0);
    look("R5", 48'h0001_7abc_def0, 1, 40'h00_babc_def0, 1, 0);
    look("R4", 48'h0001_8000_0000, 0);
  endtask

  task automatic t_invalidate();
    inval(48'h0000_7ff0_0000);
    look("R6", 48'h0000_7fe0_0000, 0);
    look("R6", 48'h0000_abcd_e000, 1, 40'hfe_dcb0_00, 1, 1);
    look("R6", 48'h0001_4000_0010, 1, 40'h00_8000_0010, 1, 0);
  endtask

  task automatic t_flush();
    flush();
    look("R7", 48'h0000_abcd_e000, 0);
    look("R7", 48'h0001_4000_0000, 0);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 4; i++) fill(48'h10000 + 48'(i) * 48'h1000, 2'd0, 28'h100 + 28'(i));
    fill(48'h14000, 2'd0, 28'h104);
    look("R8", 48'h10000, 0);
    look("R8", 48'h11000, 1, 40'h101000, 1, 1);
    look("R8", 48'h14000, 1, 40'h104000, 1, 1);
    fill(48'h15000, 2'd0, 28'h105);
    look("R8", 48'h11000, 0);
    look("R8", 48'h12000, 1, 40'h102000, 1, 1);
  endtask

  task automatic t_refill();
    fill(48'h12000, 2'd0, 28'h1c2, 1, 0);
    look("R9", 48'h12abc, 1, 40'h1c2abc, 1, 0);
    look("R9", 48'h13000, 1, 40'h103000, 1, 1);
    look("R9", 48'h14000, 1, 40'h104000, 1, 1);
    look("R9", 48'h15000, 1, 40'h105000, 1, 1);
  endtask

  task automatic t_inv_fill();
    @(negedge clk);
    inv_valid = 1'b1; inv_vaddr = 48'h13000;
    set_fill(48'h16000, 2'd0, 28'h106, 1, 1);
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0;
    look("R10", 48'h13000, 0);
    look("R10", 48'h16000, 1, 40'h106000, 1, 1);
    look("R10", 48'h12000, 1, 40'h1c2000, 1, 0);
    look("R10", 48'h14000, 1, 40'h104000, 1, 1);
    look("R10", 48'h15000, 1, 40'h105000, 1, 1);
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush_root = 1'b1;
    set_fill(48'h17000, 2'd0, 28'h107, 1, 1);
    @(negedge clk);
    flush_root = 1'b0; fill_valid = 1'b0;
    look("R11", 48'h17000, 0);
    look("R11", 48'h16000, 0);
  endtask

  task automatic t_overlap();
    fill(48'h0020_1000, 2'd0, 28'h300);
    look("R12", 48'h0020_1abc, 1, 40'h30_0abc, 1, 1);
    fill(48'h0020_0000, 2'd1, 28'h400, 1, 0);
    look("R12", 48'h0020_1abc, 1, 40'h40_1abc, 1, 0);
    look("R12", 48'h003f_f000, 1, 40'h5f_f000, 1, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_page();
    t_large_pages();
    t_invalidate();
    t_flush();
    t_replace();
    t_refill();
    t_inv_fill();
    t_flush_fill();
    t_overlap();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule